// File: doc/BRIEF.md
# Audio DMA Channel Position and Countdown Tracker

This block keeps the bookkeeping for one audio DMA channel. The channel streams through a circular buffer in host memory. That buffer is described by a base byte address and a length in 32-bit words. For every chunk that an external bus master reports as moved, the block does four things:

- advances the word position inside the buffer;
- keeps the byte remainder that did not fill a whole word;
- counts down the samples left before the next interrupt;
- produces the bus address of the next byte to move and the number of bytes left before the buffer end.

Software programs three values through a plain write port: the base address, the frame word (buffer size and current index), and the sample word (reload count and live countdown). The live halves of both count words appear on the outputs.

Transfer reports arrive on a valid/ready channel. A report is accepted on a rising edge where `xfer_valid` and `xfer_ready` are both high. The reporter must hold `xfer_bytes` stable while waiting. `xfer_ready` drops only when a one-shot buffer has run to its end. It stays low until software rewrites the frame word. The reporter must not offer more bytes than `bytes_left` shows.

Top module: `adma_chan_track`

## Requirements
- R1: After reset every count, the base address, `irq_pulse` and `irq_pending` are 0, `xfer_ready` is 1, and `bytes_left` reads 4.
- R2: A host write with `wr_sel`=0 loads `wr_data[15:0]` into the reload half (`scount[15:0]`) and leaves the countdown half (`scount[31:16]`) unchanged. `wr_sel`=1 loads the frame word (size in `[15:0]`, index in `[31:16]`) and clears the byte remainder. `wr_sel`=2 loads the base address. `wr_sel`=3 writes nothing.
- R3: The format input gives the sample shift `fmt[0]+fmt[1]`, where `fmt[0]` means two channels and `fmt[1]` means 16-bit samples. One sample frame is therefore 1, 2 or 4 bytes.
- R4: `next_addr` equals base + index×4 + remainder. `bytes_left` equals (size − index + 1)×4 + remainder, taken modulo 2^19.
- R5: An accepted transfer of at least (countdown+1)<<shift bytes expires the countdown. The countdown reloads from the reload half, and `irq_pulse` is high for the cycle after the accepting edge.
- R6: Any other accepted transfer of T bytes sets the countdown to (((countdown+1)<<shift) − T − 1)>>shift.
- R7: An accepted transfer of T bytes adds (T + remainder)>>2 to the index. The new remainder is (T + remainder) & 3.
- R8: With `loop_sel`=0, an index that moves past the size wraps by subtracting size+1.
- R9: With `loop_sel`=1, an index that moves past the size is held at the size and `xfer_ready` drops. It rises again only after a frame-word write.
- R10: `irq_pending` is set by an expiry only while `irq_en` is 1, and it clears in the cycle after `irq_en` is seen low.
- R11: When a reload-half write and an expiring transfer meet on one edge, the countdown reloads with the newly written value. When the transfer does not expire, it still updates the countdown half while the write sets the reload half.
- R12: When a frame-word write and an accepted transfer meet on one edge, the written size and index win and the remainder is 0. The countdown is still updated by the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 reload half, 1 frame word, 2 base address |
| wr_data | input | 32 | Host write data |
| fmt | input | 2 | Sample format: bit0 two channels, bit1 16-bit |
| loop_sel | input | 1 | 0 = circular buffer, 1 = one-shot buffer |
| irq_en | input | 1 | Interrupt enable for the pending bit |
| xfer_valid | input | 1 | A transfer report is offered |
| xfer_ready | output | 1 | Transfer reports can be accepted |
| xfer_bytes | input | 19 | Bytes moved by the offered transfer |
| next_addr | output | 32 | Bus address of the next byte |
| bytes_left | output | 19 | Bytes left before the buffer end |
| scount | output | 32 | Countdown half [31:16], reload half [15:0] |
| fcount | output | 32 | Live index [31:16], size in words minus one [15:0] |
| irq_pulse | output | 1 | One-cycle countdown expiry pulse |
| irq_pending | output | 1 | Latched, enable-gated interrupt request |

## Verification
Some host writes can land on the same clock edge as a transfer that updates the same count word. Two cases matter:

- A reload-half write arrives together with a transfer, both one that expires the countdown and one that does not. This shows whether the reload source is the fresh value and whether the countdown half escapes the write.
- A frame-word write arrives together with an accepted transfer. Here the written index must win while the countdown still moves.

In each case the bench drives both inputs in the same cycle. It then compares the count words, the address and the interrupt outputs one edge later against a model built from the requirements.

// File: rtl/adma_pkg.sv
package adma_pkg;

  typedef enum logic [1:0] {
    SEL_SCOUNT = 2'd0,
    SEL_FCOUNT = 2'd1,
    SEL_FBASE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // bytes per sample frame = 1 << shift
  function automatic logic [1:0] fmt_shift(input logic [1:0] f);
    return {1'b0, f[0]} + {1'b0, f[1]};
  endfunction

endpackage

// File: rtl/adma_samp_cnt.sv
module adma_samp_cnt #(
  parameter int CW  = 16,
  parameter int XBW = CW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_low,
  input  logic [CW-1:0]  wr_val,
  input  logic           accept,
  input  logic [XBW-1:0] xfer_bytes,
  input  logic [1:0]     shift,
  output logic [CW-1:0]  sc_q,
  output logic [CW-1:0]  csc_q,
  output logic           expire
);

  logic [CW-1:0]  sc_eff;
  logic [XBW-1:0] csc_ext;
  logic [XBW-1:0] csc_bytes;
  logic [XBW-1:0] remain;
  logic [XBW-1:0] rem_sh;
  logic [CW-1:0]  csc_next;

  always_comb begin
    sc_eff    = wr_low ? wr_val : sc_q;
    csc_ext   = {{(XBW-CW){1'b0}}, csc_q};
    csc_bytes = (csc_ext + XBW'(1)) << shift;
    expire    = accept && (xfer_bytes >= csc_bytes);
    remain    = csc_bytes - xfer_bytes - XBW'(1);
    rem_sh    = remain >> shift;
    if (expire)      csc_next = sc_eff;
    else if (accept) csc_next = rem_sh[CW-1:0];
    else             csc_next = csc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q  <= '0;
      csc_q <= '0;
    end else begin
      sc_q  <= sc_eff;
      csc_q <= csc_next;
    end
  end

  // R6: a partial transfer never raises the countdown
  p_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !expire) |=> (csc_q <= $past(csc_q)));

endmodule

// File: rtl/adma_frame_pos.sv
module adma_frame_pos #(
  parameter int CW  = 16,
  parameter int XBW = CW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_frame,
  input  logic [2*CW-1:0] wr_val,
  input  logic            accept,
  input  logic [XBW-1:0]  xfer_bytes,
  input  logic            loop_sel,
  output logic [CW-1:0]   size_q,
  output logic [CW-1:0]   idx_q,
  output logic [1:0]      left_q,
  output logic            halt_q
);

  localparam int IW = CW + 2;

  logic [XBW-1:0] sum;
  logic [XBW-3:0] step;
  logic [IW-1:0]  idx_sum;
  logic [IW-1:0]  size_ext;
  logic [IW-1:0]  wrapped;
  logic           past_end;

  always_comb begin
    sum      = xfer_bytes + {{(XBW-2){1'b0}}, left_q};
    step     = sum[XBW-1:2];
    idx_sum  = {2'b00, idx_q} + {1'b0, step};
    size_ext = {2'b00, size_q};
    past_end = idx_sum > size_ext;
    wrapped  = idx_sum - size_ext - IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      halt_q <= 1'b0;
    end else if (wr_frame) begin
      size_q <= wr_val[CW-1:0];
      idx_q  <= wr_val[2*CW-1:CW];
      left_q <= '0;
      halt_q <= 1'b0;
    end else if (accept) begin
      left_q <= sum[1:0];
      if (!past_end) begin
        idx_q <= idx_sum[CW-1:0];
      end else if (!loop_sel) begin
        idx_q <= wrapped[CW-1:0];
      end else begin
        idx_q  <= size_q;
        halt_q <= 1'b1;
      end
    end
  end

  // R9: a stopped one-shot buffer keeps its index until rewritten
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_frame && !accept) |=> (halt_q && $stable(idx_q)));

endmodule

// File: rtl/adma_chan_track.sv
module adma_chan_track
  import adma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic [1:0]      fmt,
  input  logic            loop_sel,
  input  logic            irq_en,
  input  logic            xfer_valid,
  output logic            xfer_ready,
  input  logic [CW+2:0]   xfer_bytes,
  output logic [AW-1:0]   next_addr,
  output logic [CW+2:0]   bytes_left,
  output logic [2*CW-1:0] scount,
  output logic [2*CW-1:0] fcount,
  output logic            irq_pulse,
  output logic            irq_pending
);

  localparam int XBW = CW + 3;

  logic          accept, wr_low, wr_frame, wr_base;
  logic [1:0]    shift;
  logic [CW-1:0] sc_q, csc_q, size_q, idx_q;
  logic [1:0]    left_q;
  logic          halt_q, expire;
  logic [AW-1:0] base_q;
  logic          pulse_q, pend_q;
  logic [XBW-1:0] span;

  always_comb begin
    wr_low   = wr_en && (wr_sel == SEL_SCOUNT);
    wr_frame = wr_en && (wr_sel == SEL_FCOUNT);
    wr_base  = wr_en && (wr_sel == SEL_FBASE);
    shift    = fmt_shift(fmt);
    xfer_ready = !halt_q;
    accept   = xfer_valid && xfer_ready;
  end

  adma_samp_cnt #(.CW(CW), .XBW(XBW)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_low     (wr_low),
    .wr_val     (wr_data[CW-1:0]),
    .accept     (accept),
    .xfer_bytes (xfer_bytes),
    .shift      (shift),
    .sc_q       (sc_q),
    .csc_q      (csc_q),
    .expire     (expire)
  );

  adma_frame_pos #(.CW(CW), .XBW(XBW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_frame   (wr_frame),
    .wr_val     (wr_data[2*CW-1:0]),
    .accept     (accept),
    .xfer_bytes (xfer_bytes),
    .loop_sel   (loop_sel),
    .size_q     (size_q),
    .idx_q      (idx_q),
    .left_q     (left_q),
    .halt_q     (halt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_base) base_q <= wr_data;
      pulse_q <= expire;
      pend_q  <= irq_en && (pend_q || expire);
    end
  end

  always_comb begin
    span       = {3'b000, size_q} - {3'b000, idx_q} + XBW'(1);
    bytes_left = {span[CW:0], 2'b00} + {{(CW+1){1'b0}}, left_q};
    next_addr  = base_q + {{(AW-CW-2){1'b0}}, idx_q, 2'b00}
                        + {{(AW-2){1'b0}}, left_q};
    scount     = {csc_q, sc_q};
    fcount     = {idx_q, size_q};
    irq_pulse  = pulse_q;
    irq_pending = pend_q;
  end

  // R5: a pulse only follows an accepted transfer
  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(xfer_valid && xfer_ready));

  // R10: the pending bit needs the enable seen at the previous edge
  p_pend_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> $past(irq_en));

  // R9: ready returns only through a frame-word write
  p_ready_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ready |=> (!xfer_ready || $past(wr_en && wr_sel == SEL_FCOUNT)));

  // R4: address and remaining count move only with a write or a transfer
  p_addr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !accept) |=> ($stable(next_addr) && $stable(bytes_left)));

endmodule

// File: tb/adma_chan_track_test.sv
`timescale 1ns/1ps
module adma_chan_track_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  fmt;
  logic        loop_sel;
  logic        irq_en;
  logic        xfer_valid;
  logic        xfer_ready;
  logic [18:0] xfer_bytes;
  logic [31:0] next_addr;
  logic [18:0] bytes_left;
  logic [31:0] scount;
  logic [31:0] fcount;
  logic        irq_pulse;
  logic        irq_pending;

  always #4 clk = ~clk;

  adma_chan_track uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fmt(fmt), .loop_sel(loop_sel), .irq_en(irq_en), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_bytes(xfer_bytes), .next_addr(next_addr),
    .bytes_left(bytes_left), .scount(scount), .fcount(fcount),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  typedef struct packed {
    logic [31:0] sc;
    logic [31:0] fc;
    logic [31:0] addr;
    logic [18:0] left;
    logic        pulse;
    logic        pend;
    logic        rdy;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  sample_ev;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // reference model state
  int unsigned m_sc, m_csc, m_size, m_idx, m_left, m_base;
  bit m_halt, m_pend;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "scount",  scount, e.sc);
        chk(t, "fcount",  fcount, e.fc);
        chk(t, "addr",    next_addr, e.addr);
        chk(t, "left",    {13'd0, bytes_left}, {13'd0, e.left});
        chk(t, "pulse",   {31'd0, irq_pulse}, {31'd0, e.pulse});
        chk(t, "pending", {31'd0, irq_pending}, {31'd0, e.pend});
        chk(t, "ready",   {31'd0, xfer_ready}, {31'd0, e.rdy});
      end
    end
  end

  function automatic exp_t model_out(input bit pulse);
    exp_t e;
    e.sc    = {m_csc[15:0], m_sc[15:0]};
    e.fc    = {m_idx[15:0], m_size[15:0]};
    e.addr  = m_base + m_idx * 4 + m_left;
    e.left  = 19'((m_size - m_idx + 1) * 4 + m_left);
    e.pulse = pulse;
    e.pend  = m_pend;
    e.rdy   = !m_halt;
    return e;
  endfunction

  task automatic op(input string tag, input bit wr, input logic [1:0] sel,
                    input logic [31:0] data, input bit xv, input int unsigned nb);
    int unsigned sh, cb, sc_eff, sum, ni;
    bit acc, fire;
    @(negedge clk);
    wr_en = wr; wr_sel = sel; wr_data = data;
    xfer_valid = xv; xfer_bytes = 19'(nb);
    sh     = fmt[0] + fmt[1];
    acc    = xv && !m_halt;
    sc_eff = (wr && sel == 2'd0) ? data[15:0] : m_sc;
    fire   = 1'b0;
    if (acc) begin
      cb = (m_csc + 1) << sh;
      if (nb >= cb) begin
        fire = 1'b1;
        m_csc = sc_eff;
      end else begin
        m_csc = (cb - nb - 1) >> sh;
      end
    end
    m_sc = sc_eff;
    if (wr && sel == 2'd1) begin
      m_size = data[15:0]; m_idx = data[31:16]; m_left = 0; m_halt = 1'b0;
    end else if (acc) begin
      sum = nb + m_left;
      ni  = m_idx + (sum >> 2);
      m_left = sum & 3;
      if (ni > m_size) begin
        if (!loop_sel) ni = ni - (m_size + 1);
        else begin ni = m_size; m_halt = 1'b1; end
      end
      m_idx = ni;
    end
    if (wr && sel == 2'd2) m_base = data;
    m_pend = irq_en && (m_pend || fire);
    @(posedge clk);
    #1;
    exp_q.push_back(model_out(fire));
    tag_q.push_back(tag);
    ->sample_ev;
    #1;
    wr_en = 1'b0; xfer_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    fmt = 2'd0; loop_sel = 1'b0; irq_en = 1'b1; xfer_valid = 1'b0; xfer_bytes = '0;
    m_sc = 0; m_csc = 0; m_size = 0; m_idx = 0; m_left = 0; m_base = 0;
    m_halt = 1'b0; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    op("R1 reset", 1'b0, 2'd3, 32'h0, 1'b0, 0);
    op("R2 base", 1'b1, 2'd2, 32'h1000_0000, 1'b0, 0);
    op("R2 frame", 1'b1, 2'd1, 32'h0000_000F, 1'b0, 0);
    op("R2 low half", 1'b1, 2'd0, 32'hFFFF_0007, 1'b0, 0);
    op("R2 no-write sel", 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, 0);
    op("R5 expire mono8", 1'b0, 2'd3, 32'h0, 1'b1, 1);
    fmt = 2'd3;
    op("R3 R6 R7 partial", 1'b0, 2'd3, 32'h0, 1'b1, 6);
    op("R6 R7 partial2", 1'b0, 2'd3, 32'h0, 1'b1, 26);
    irq_en = 1'b0;
    op("R10 pend clears", 1'b0, 2'd3, 32'h0, 1'b0, 0);
    op("R5 R10 expire no-en", 1'b0, 2'd3, 32'h0, 1'b1, 4);
    irq_en = 1'b1;
    op("R8 wrap", 1'b0, 2'd3, 32'h0, 1'b1, 40);
    op("R4 addr idle", 1'b0, 2'd3, 32'h0, 1'b0, 0);
    fmt = 2'd1;
    op("R3 stereo8 partial", 1'b0, 2'd3, 32'h0, 1'b1, 3);
    op("R11 write+partial", 1'b1, 2'd0, 32'h0000_0003, 1'b1, 2);
    op("R11 write+expire", 1'b1, 2'd0, 32'h0000_0009, 1'b1, 200);
    op("R12 frame+xfer", 1'b1, 2'd1, 32'h0002_0020, 1'b1, 5);
    fmt = 2'd2;
    op("R3 16bit partial", 1'b0, 2'd3, 32'h0, 1'b1, 7);
    loop_sel = 1'b1;
    op("R9 frame set", 1'b1, 2'd1, 32'h0002_0003, 1'b0, 0);
    op("R9 saturate", 1'b0, 2'd3, 32'h0, 1'b1, 12);
    op("R9 refused", 1'b0, 2'd3, 32'h0, 1'b1, 4);
    op("R9 rewrite", 1'b1, 2'd1, 32'h0000_0007, 1'b0, 0);
    op("R9 resume", 1'b0, 2'd3, 32'h0, 1'b1, 8);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule